// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital front end of a 12-bit serial-input converter. A host sends a 16-bit word one bit at a time. Each bit is taken on a falling edge of a serial clock while an active-low frame strobe is held low. The word arrives most significant bit first. Its four leading bits are ignored and its trailing twelve bits form the converter code. Once a word is complete, the code moves into a holding latch, and the latch drives the converter. The move happens either automatically on the sixteenth edge or later on a falling edge of an active-low load strobe. The level of the load strobe at the start of the frame picks which of the two applies.

All host pins are asynchronous to the block. They are re-timed by two-flop synchronizers onto a system clock that runs at least four times faster than the serial clock, and every edge is detected in that clock domain. A chain-enable input removes the sixteen-edge limit. In that mode the register's top bit leaves on a serial output, so several devices can share one data line. An active-low clear forces the latch to zero. A format select chooses between straight/offset binary and two's-complement coding. For two's complement, the top bit of the code sent to the converter is inverted.

Top module: `serial_dac_frontend`

## Requirements
- R1: With the frame strobe low, each falling serial-clock edge shifts the data pin into the low end of a 16-bit register. After a full word, the latch code equals word bits [11:0], so the last bit sent is the code LSB and the first four bits have no effect.
- R2: A falling edge of the frame strobe restarts the edge count. If the strobe rises before the sixteenth edge, no automatic update takes place, and the next frame loads normally.
- R3: With chain enable low, only the first 16 falling edges after the frame starts shift the register. Further edges in the same frame are ignored.
- R4: While the frame strobe is high, serial-clock edges leave the register unchanged.
- R5: If the load strobe is low when the frame starts, the latch loads the register payload right after the sixteenth edge.
- R6: If the load strobe is high when the frame starts, the latch holds its value through the frame. It loads on the next falling edge of the load strobe, but only if that frame completed all 16 edges; otherwise the load edge is ignored.
- R7: While the synchronized clear is low, the latch is zero and no load can change it.
- R8: The update strobe is high for exactly one system-clock cycle each time the latch value changes, and never at any other time.
- R9: With format select low, the output code equals the latch. With format select high, the output code is the latch with bit 11 inverted, so a cleared latch gives 0x000 and 0x800 respectively.
- R10: With chain enable high, the serial output carries register bit 15 and follows each shift. After edge n (n ≥ 16), it carries stream bit n−16. With chain enable low, the serial output is 0.
- R11: With chain enable high, there is no edge limit. After 32 edges the register holds the last 16 bits sent, and a load edge transfers their low 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock; data taken on falling edges |
| sdin_i | input | 1 | Serial data in, MSB first |
| sync_n_i | input | 1 | Active-low frame strobe |
| ldac_n_i | input | 1 | Active-low load strobe; also selects update mode at frame start |
| clr_n_i | input | 1 | Active-low latch clear |
| chain_en_i | input | 1 | 1 = chained mode without edge limit, serial output enabled |
| twos_comp_i | input | 1 | 1 = two's-complement coding (MSB inverted at output) |
| sdo_o | output | 1 | Serial data out (register MSB in chained mode) |
| dac_code_o | output | 12 | Code applied to the converter |
| latch_update_o | output | 1 | One-cycle strobe when the latch changes |

## Verification
The embedded assertions check on every cycle that the register is frozen outside a frame and after the edge limit. They also check that a clear forces zero, that a deferred-mode latch moves only on a load edge, and that the update strobe matches latch changes exactly. The following can only be shown by the bench scenarios: the bit ordering and payload selection, the discarded leading bits and surplus edges, partial frames, the chained output stream, and the output coding. The bench does this by sweeping codes across the 12-bit range and comparing against values it computes itself.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // bit positions of the synchronized pin bundle
  localparam int PIN_COUNT = 5;
  localparam int PIN_SCLK  = 4;
  localparam int PIN_SDIN  = 3;
  localparam int PIN_FRAME = 2;
  localparam int PIN_LOAD  = 1;
  localparam int PIN_CLEAR = 0;
  // idle levels of the pins after reset: clock high, strobes high, data low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 5'b10111;

  typedef enum logic {
    UPD_AUTO   = 1'b0,
    UPD_MANUAL = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              frame_n_s,
  input  logic              chain_en,
  output logic              frame_start_o,
  output logic              word_done_o,
  output logic [CODE_W-1:0] payload_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d, frame_d;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sr_q, sr_n;
  logic              done_q, done_n;
  logic              sclk_fall, gate_open, shift_en;

  // edge detection and gating
  always_comb begin
    sclk_fall     = sclk_d & ~sclk_s;
    frame_start_o = frame_d & ~frame_n_s;
    gate_open     = chain_en | (cnt_q < CNT_FULL);
    shift_en      = sclk_fall & ~frame_n_s & gate_open & ~frame_start_o;
  end

  // next state
  always_comb begin
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (shift_en) begin
      sr_n = {sr_q[WORD_W-2:0], sdin_s};
      if (cnt_q != CNT_FULL) cnt_n = cnt_q + 1'b1;
      done_n = (cnt_q == CNT_LAST);
    end
    if (frame_start_o) cnt_n = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      frame_d <= 1'b1;
      cnt_q   <= CNT_FULL;
      sr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_n_s;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      done_q  <= done_n;
    end
  end

  assign word_done_o = done_q;
  assign payload_o   = sr_q[CODE_W-1:0];
  assign sdo_o       = chain_en & sr_q[WORD_W-1];

  // R4: outside a frame the register does not move
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |=> $stable(sr_q));

  // R3: after the edge limit in standalone mode the register is frozen
  a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en && cnt_q == CNT_FULL) |=> $stable(sr_q));

  // R2: completion is reported only once the count has reached a full word
  a_r2_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == CNT_FULL));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              word_done,
  input  logic [CODE_W-1:0] payload,
  input  logic              load_n_s,
  input  logic              clr_n_s,
  output logic [CODE_W-1:0] latch_o,
  output logic              update_o
);
  upd_mode_e         mode_q, mode_n;
  logic              ready_q, ready_n;
  logic              load_d;
  logic [CODE_W-1:0] latch_q, latch_n;
  logic              upd_q, upd_n;
  logic              load_fall, load_auto, load_man;

  always_comb begin
    load_fall = load_d & ~load_n_s;
    load_auto = word_done & (mode_q == UPD_AUTO);
    load_man  = load_fall & (mode_q == UPD_MANUAL) & ready_q;
  end

  // next state
  always_comb begin
    mode_n  = mode_q;
    ready_n = ready_q;
    if (word_done) ready_n = 1'b1;
    if (frame_start) begin
      mode_n  = load_n_s ? UPD_MANUAL : UPD_AUTO;
      ready_n = 1'b0;
    end
    latch_n = latch_q;
    if (load_auto || load_man) latch_n = payload;
    if (!clr_n_s) latch_n = '0;
    upd_n = (latch_n != latch_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= UPD_MANUAL;
      ready_q <= 1'b0;
      load_d  <= 1'b1;
      latch_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      ready_q <= ready_n;
      load_d  <= load_n_s;
      latch_q <= latch_n;
      upd_q   <= upd_n;
    end
  end

  assign latch_o  = latch_q;
  assign update_o = upd_q;

  // R7: a clear forces the latch to zero
  a_r7_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_s |=> (latch_q == '0));

  // R6: in deferred mode nothing but a load edge or a clear moves the latch
  a_r6_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == UPD_MANUAL && !load_fall && clr_n_s) |=> $stable(latch_q));

  // R8: strobe coincides with a latch change, in both directions
  a_r8_strobe_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (latch_q != $past(latch_q)));
  a_r8_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q != $past(latch_q)) |-> upd_q);
endmodule

// File: rtl/sdac_format.sv
module sdac_format #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] latch_i,
  input  logic              twos_comp,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o = latch_i;
    if (twos_comp) code_o[CODE_W-1] = ~latch_i[CODE_W-1];
  end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import sdac_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              sync_n_i,
  input  logic              ldac_n_i,
  input  logic              clr_n_i,
  input  logic              chain_en_i,
  input  logic              twos_comp_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              latch_update_o
);
  logic [1:0]              rst_q;
  logic                    rst_int_n;
  logic [PIN_COUNT-1:0]    pins_raw, pins_s;
  logic                    frame_start, word_done;
  logic [CODE_W-1:0]       payload, latch_val;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SCLK]  = sclk_i;
    pins_raw[PIN_SDIN]  = sdin_i;
    pins_raw[PIN_FRAME] = sync_n_i;
    pins_raw[PIN_LOAD]  = ldac_n_i;
    pins_raw[PIN_CLEAR] = clr_n_i;
  end

  sdac_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  sdac_shifter #(
    .WORD_W(WORD_W),
    .CODE_W(CODE_W)
  ) u_shifter (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sclk_s       (pins_s[PIN_SCLK]),
    .sdin_s       (pins_s[PIN_SDIN]),
    .frame_n_s    (pins_s[PIN_FRAME]),
    .chain_en     (chain_en_i),
    .frame_start_o(frame_start),
    .word_done_o  (word_done),
    .payload_o    (payload),
    .sdo_o        (sdo_o)
  );

  sdac_latch #(
    .CODE_W(CODE_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_start(frame_start),
    .word_done  (word_done),
    .payload    (payload),
    .load_n_s   (pins_s[PIN_LOAD]),
    .clr_n_s    (pins_s[PIN_CLEAR]),
    .latch_o    (latch_val),
    .update_o   (latch_update_o)
  );

  sdac_format #(
    .CODE_W(CODE_W)
  ) u_format (
    .latch_i  (latch_val),
    .twos_comp(twos_comp_i),
    .code_o   (dac_code_o)
  );
endmodule

// File: tb/serial_dac_frontend_tb.sv
module serial_dac_frontend_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sclk, sdin, sync_n, ldac_n, clr_n, chain_en, twos;
  logic        sdo, upd;
  logic [11:0] code;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  int exp_strobes = 0;
  logic [11:0] mdl = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && upd) strobes <= strobes + 1;

  serial_dac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sync_n_i(sync_n),
    .ldac_n_i(ldac_n), .clr_n_i(clr_n), .chain_en_i(chain_en), .twos_comp_i(twos),
    .sdo_o(sdo), .dac_code_o(code), .latch_update_o(upd)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // model of the latch: counts expected strobes
  task automatic model_set(input logic [11:0] v);
    if (v != mdl) exp_strobes++;
    mdl = v;
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input logic ldac_lvl,
                       input bit chk_sdo);
    ldac_n = ldac_lvl;
    wait_clk(4);
    sync_n = 1'b0;
    wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = bits[i];
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      if (chk_sdo && (n - i) >= 16)
        check("R10 sdo stream", int'(sdo), int'(bits[n - 1 - ((n - i) - 16)]));
      sclk = 1'b1;
    end
    wait_clk(6);
    sync_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic load_pulse();
    ldac_n = 1'b0;
    wait_clk(8);
    ldac_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sclk = 1; sdin = 0; sync_n = 1; ldac_n = 1; clr_n = 1;
    chain_en = 0; twos = 0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(6);

    // reset state
    check("R9 reset code offset", int'(code), 0);
    check("R10 reset sdo", int'(sdo), 0);
    twos = 1;
    #1 check("R9 reset code twos", int'(code), 'h800);
    twos = 0;
    check("R8 no strobe at reset", strobes, 0);

    // R1 R5 R9: automatic-mode sweep over the code range
    for (int c = 0; c < 4096 + 41; c += 41) begin
      int cv = (c > 4095) ? 4095 : c;
      logic [15:0] w = {4'hA, 12'(cv)};
      frame({16'h0, w}, 16, 1'b0, 0);
      model_set(12'(cv));
      check("R1 R5 auto load", int'(code), cv);
      twos = 1;
      #1 check("R9 twos remap", int'(code), cv ^ 'h800);
      twos = 0;
    end
    check("R8 strobe count after sweep", strobes, exp_strobes);

    // R3: surplus edges in standalone mode are ignored
    frame({12'h0, 16'hF5A3, 4'hF}, 20, 1'b0, 0);
    model_set(12'h5A3);
    check("R3 extra edges ignored", int'(code), 'h5A3);
    check("R10 sdo low standalone", int'(sdo), 0);

    // R2: partial frame gives no update, next frame loads
    frame({22'h0, 10'h3C5}, 10, 1'b0, 0);
    check("R2 partial no update", int'(code), 'h5A3);
    frame({16'h0, 16'h0123}, 16, 1'b0, 0);
    model_set(12'h123);
    check("R2 count restart", int'(code), 'h123);

    // R6: deferred update
    frame({16'h0, 16'h7ABC}, 16, 1'b1, 0);
    check("R6 held until load", int'(code), 'h123);
    // R4: clocks with frame high must not disturb the register
    sdin = 1;
    for (int k = 0; k < 16; k++) begin
      wait_clk(4); sclk = 0; wait_clk(4); sclk = 1;
    end
    wait_clk(4);
    load_pulse();
    model_set(12'hABC);
    check("R4 R6 load after idle clocks", int'(code), 'hABC);
    // R6: load edge after an incomplete deferred frame is ignored
    frame({24'h0, 8'h55}, 8, 1'b1, 0);
    load_pulse();
    check("R6 load ignored incomplete", int'(code), 'hABC);
    check("R8 strobe count deferred", strobes, exp_strobes);

    // R7: clear dominates
    clr_n = 0;
    wait_clk(6);
    model_set(12'h000);
    check("R7 clear offset", int'(code), 0);
    twos = 1;
    #1 check("R7 R9 clear twos midscale", int'(code), 'h800);
    twos = 0;
    frame({16'h0, 16'h0FFF}, 16, 1'b0, 0);
    check("R7 load blocked by clear", int'(code), 0);
    clr_n = 1;
    wait_clk(6);
    check("R7 stays zero after release", int'(code), 0);
    check("R8 strobe count clear", strobes, exp_strobes);

    // R10 R11: chained mode, two words, deferred load
    chain_en = 1;
    wait_clk(2);
    frame({16'hB2C7, 16'h4E19}, 32, 1'b1, 1);
    check("R11 chain holds last word before load", int'(code), 0);
    load_pulse();
    model_set(12'hE19);
    check("R11 chain load last word", int'(code), 'hE19);
    check("R10 sdo shows reg msb", int'(sdo), 0);
    chain_en = 0;
    wait_clk(2);
    check("R8 strobe count final", strobes, exp_strobes);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule